// File: doc/BRIEF.md
# Reconfigurable 64-Bit Look-Up Table Cell

This block is a single logic cell built around a 64-bit truth table. The table is split into four 16-entry quarters (Q0 to Q3). Q0 and Q1 form the low half, which is addressed from bus `b`. Q2 and Q3 form the high half, which is addressed from bus `a`. Quarter Qn always drives output `f[n]`.

A 6-bit mode word picks how the same ports are used:
- **Per-half logic:** each half is set up on its own as two 4-input functions, one 5-input function, or a 16x2 RAM that is written while the clock is low.
- **Ripple:** a 4-bit ripple function whose per-bit sum and carry come from the table.
- **Synchronous RAM:** a 16x4 single-port RAM or a 16x2 dual-port RAM.

In the RAM modes `c0` is the write enable and `wd` carries the write data. In the per-half logic mode, the output `f_wide` gives a 6-input function with `c0` as the sixth input.

The table and the mode word are loaded together through a parallel configuration port. A load takes one clock edge. The asynchronous active-low reset clears both the table and the mode word, and the reset is released synchronously inside the block.

Top module: `mlut_cell`

## Requirements
- R1: While reset is active, and after it, until the first load: table = 0 and mode = 0. So `f`, `f_wide` and `co` read 0.
- R2: `cfg_load` high at a rising edge stores `cfg_table` and `cfg_mode`. This load overrides any memory write at the same edge. Table bit `16*n+k` is entry k of quarter Qn. The mode fields are:
  - `cfg_mode[5:4]`: 0 = per-half logic, 1 = ripple, 2 = 16x4 single-port RAM, 3 = 16x2 dual-port RAM.
  - `cfg_mode[3:2]`: kind of the high half. 0 = split, 1 = five-input, 2 = RAM written while the clock is low, 3 = treated as split.
  - `cfg_mode[1:0]`: kind of the low half, using the same encoding.
- R3: A half of kind split gives `f[0] = Q0[b[3:0]]` and `f[1] = Q1[{b[4],b[2:0]}]` for the low half. For the high half it gives `f[2] = Q2[a[3:0]]` and `f[3] = Q3[{a[4],a[2:0]}]`.
- R4: A half of kind five-input drives both of its outputs with table bit `b[4:0]` (low half) or table bit `32+a[4:0]` (high half).
- R5: In per-half logic mode, `f_wide` equals table bit `32+a[4:0]` when `c0 = 1` and table bit `b[4:0]` when `c0 = 0`. In every other mode, `f_wide` is 0.
- R6: In ripple mode, the carry into bit 0 is `b[4]`. For bit i, `f[i] = Qi[{0,c_i,a[i],b[i]}]` and `c_(i+1) = Qi[{1,c_i,a[i],b[i]}]`, and `co = c_4`. In all other modes `co` is 0. Ripple mode never writes the table.
- R7: A half of kind clock-low RAM reads combinationally at its 4-bit address (`b[3:0]` for the low half, `a[3:0]` for the high half). While `clk` is low and `c0 = 1`, each output of that half shows its `wd` bit (`wd[n]` for `f[n]`). The value present at the next rising edge is stored.
- R8: In single-port mode, `f[n] = Qn[a[3:0]]`. When `c0 = 1`, a rising edge writes `wd[n]` into `Qn[a[3:0]]`.
- R9: In dual-port mode, a rising edge with `c0 = 1` writes `wd[0]` into Q0 and Q2 and `wd[1]` into Q1 and Q3, all at `a[3:0]`. Q0 and Q1 are read at `a[3:0]`; Q2 and Q3 are read at `b[3:0]`. A read of the address being written returns the old data until the edge.
- R10: With `c0 = 0`, no RAM mode changes the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its low phase is the write window of the clock-low RAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads table and mode at the rising edge |
| cfg_mode | input | 6 | Mode word to load |
| cfg_table | input | 64 | Table contents to load |
| a | input | 5 | High-half address / ripple operand A |
| b | input | 5 | Low-half address / ripple operand B, carry-in on bit 4 |
| c0 | input | 1 | Sixth logic input; write enable in RAM modes |
| wd | input | 4 | Write data |
| f | output | 4 | Quarter outputs, bit n from quarter n |
| f_wide | output | 1 | Six-input function output |
| co | output | 1 | Ripple carry-out |

## Verification
Two things can meet in one cycle: a write and a read of the same address. The bench provokes this by driving `c0` high with the write and read addresses equal, then samples the outputs during the clock-low phase before the edge.

In dual-port mode the read must still return the old contents. In clock-low RAM mode it must already show `wd`, because the write is transparent. A second check after the edge confirms the stored value in both modes.

A configuration load raised together with a single-port write is judged by reading back the loaded contents, which must replace the written bit.

// File: rtl/mlut_pkg.sv
`timescale 1ns/1ps
package mlut_pkg;
  localparam int NQ = 4;  // quarters per table

  typedef enum logic [1:0] {
    WH_PERHALF = 2'd0,
    WH_RIPPLE  = 2'd1,
    WH_SPRAM   = 2'd2,
    WH_DPRAM   = 2'd3
  } whole_e;

  typedef enum logic [1:0] {
    HK_SPLIT = 2'd0,
    HK_FUNC5 = 2'd1,
    HK_ARAM  = 2'd2,
    HK_SPARE = 2'd3
  } half_e;

  typedef struct packed {
    whole_e whole;
    half_e  kind_hi;
    half_e  kind_lo;
  } mode_t;
endpackage

// File: rtl/mlut_store.sv
`timescale 1ns/1ps
module mlut_store import mlut_pkg::*; #(
  parameter int ADDR_W = 4,
  localparam int QD = 1 << ADDR_W,
  localparam int TW = NQ * QD,
  localparam int IN_W = ADDR_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [5:0]      cfg_mode,
  input  logic [TW-1:0]   cfg_table,
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  input  logic            c0,
  input  logic [NQ-1:0]   wd,
  output logic [TW-1:0]   table_q,
  output mode_t           mode_q
);
  logic [TW-1:0]     table_d;
  mode_t             mode_d;
  logic [NQ-1:0]     we;
  logic [NQ-1:0]     wbit;
  logic [ADDR_W-1:0] waddr [NQ];
  logic              upd;

  // per-quarter write steering
  for (genvar gq = 0; gq < NQ; gq++) begin : g_wr
    localparam bit HI = (gq >= NQ/2);
    half_e            kind;
    logic [IN_W-1:0]  bus;
    assign kind = HI ? mode_q.kind_hi : mode_q.kind_lo;
    assign bus  = HI ? a : b;
    always_comb begin
      we[gq]    = 1'b0;
      waddr[gq] = a[ADDR_W-1:0];
      wbit[gq]  = wd[gq];
      unique case (mode_q.whole)
        WH_SPRAM: we[gq] = c0;
        WH_DPRAM: begin
          we[gq]   = c0;
          wbit[gq] = wd[gq % 2];
        end
        WH_PERHALF: begin
          we[gq]    = c0 && (kind == HK_ARAM);
          waddr[gq] = bus[ADDR_W-1:0];
        end
        default: we[gq] = 1'b0;
      endcase
    end
  end

  assign upd = cfg_load | (|we);

  always_comb begin
    table_d = table_q;
    mode_d  = mode_q;
    if (cfg_load) begin
      table_d = cfg_table;
      mode_d  = mode_t'(cfg_mode);
    end else begin
      for (int i = 0; i < NQ; i++)
        if (we[i]) table_d[i*QD + int'(waddr[i])] = wbit[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      table_q <= '0;
      mode_q  <= mode_t'('0);
    end else if (upd) begin
      table_q <= table_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/mlut_read.sv
`timescale 1ns/1ps
module mlut_read import mlut_pkg::*; #(
  parameter int ADDR_W = 4,
  localparam int QD = 1 << ADDR_W,
  localparam int TW = NQ * QD,
  localparam int IN_W = ADDR_W + 1
) (
  input  logic            clk,
  input  logic [TW-1:0]   table_q,
  input  mode_t           mode_q,
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  input  logic            c0,
  input  logic [NQ-1:0]   wd,
  output logic [NQ-1:0]   f,
  output logic            f_wide,
  output logic            co
);
  logic [QD-1:0] qv [NQ];
  logic [NQ-1:0] f_sp, f_dp, f_rip, f_half;
  logic [NQ:0]   cy;
  logic [1:0]    h5;
  logic [1:0]    hp [2];
  logic          byp;

  assign byp   = c0 & ~clk;
  assign cy[0] = b[IN_W-1];

  for (genvar gq = 0; gq < NQ; gq++) begin : g_q
    assign qv[gq]    = table_q[gq*QD +: QD];
    assign f_rip[gq] = qv[gq][ADDR_W'({1'b0, cy[gq], a[gq], b[gq]})];
    assign cy[gq+1]  = qv[gq][ADDR_W'({1'b1, cy[gq], a[gq], b[gq]})];
    assign f_sp[gq]  = qv[gq][a[ADDR_W-1:0]];
    if (gq >= NQ/2) begin : g_rd_b
      assign f_dp[gq] = qv[gq][b[ADDR_W-1:0]];
    end else begin : g_rd_a
      assign f_dp[gq] = qv[gq][a[ADDR_W-1:0]];
    end
  end

  for (genvar gh = 0; gh < 2; gh++) begin : g_half
    localparam int LO = 2*gh;
    localparam int HI = 2*gh + 1;
    logic [IN_W-1:0] x;
    half_e           kind;
    assign x    = (gh == 1) ? a : b;
    assign kind = (gh == 1) ? mode_q.kind_hi : mode_q.kind_lo;
    assign h5[gh] = x[IN_W-1] ? qv[HI][x[ADDR_W-1:0]] : qv[LO][x[ADDR_W-1:0]];
    always_comb begin
      unique case (kind)
        HK_FUNC5: hp[gh] = {h5[gh], h5[gh]};
        HK_ARAM:  hp[gh] = byp ? {wd[HI], wd[LO]}
                               : {qv[HI][x[ADDR_W-1:0]], qv[LO][x[ADDR_W-1:0]]};
        default:  hp[gh] = {qv[HI][{x[IN_W-1], x[ADDR_W-2:0]}], qv[LO][x[ADDR_W-1:0]]};
      endcase
    end
  end

  assign f_half = {hp[1], hp[0]};

  always_comb begin
    f      = '0;
    f_wide = 1'b0;
    co     = 1'b0;
    unique case (mode_q.whole)
      WH_PERHALF: begin
        f      = f_half;
        f_wide = c0 ? h5[1] : h5[0];
      end
      WH_RIPPLE: begin
        f  = f_rip;
        co = cy[NQ];
      end
      WH_SPRAM: f = f_sp;
      default:  f = f_dp;
    endcase
  end
endmodule

// File: rtl/mlut_cell.sv
`timescale 1ns/1ps
module mlut_cell import mlut_pkg::*; #(
  parameter int ADDR_W = 4,
  localparam int QD = 1 << ADDR_W,
  localparam int TW = NQ * QD,
  localparam int IN_W = ADDR_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [5:0]      cfg_mode,
  input  logic [TW-1:0]   cfg_table,
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  input  logic            c0,
  input  logic [NQ-1:0]   wd,
  output logic [NQ-1:0]   f,
  output logic            f_wide,
  output logic            co
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [TW-1:0] table_q;
  mode_t         mode_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mlut_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_table(cfg_table), .a(a), .b(b), .c0(c0), .wd(wd),
    .table_q(table_q), .mode_q(mode_q)
  );

  mlut_read #(.ADDR_W(ADDR_W)) u_read (
    .clk(clk), .table_q(table_q), .mode_q(mode_q), .a(a), .b(b), .c0(c0),
    .wd(wd), .f(f), .f_wide(f_wide), .co(co)
  );
endmodule

// File: rtl/mlut_cell_chk.sv
`timescale 1ns/1ps
module mlut_cell_chk #(
  parameter int ADDR_W = 4,
  localparam int TW = 4 << ADDR_W,
  localparam int IN_W = ADDR_W + 1
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            cfg_load,
  input logic [5:0]      cfg_mode,
  input logic [IN_W-1:0] a,
  input logic            c0,
  input logic [3:0]      wd,
  input logic [3:0]      f,
  input logic            f_wide,
  input logic            co,
  input logic [5:0]      mode_q,
  input logic [TW-1:0]   table_q
);
  // R2: a load sets the mode word at the next edge
  assert_cfg_mode_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_load |=> (mode_q == $past(cfg_mode)));

  // R6: ripple mode leaves the table untouched
  assert_ripple_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q[5:4] == 2'd1 && !cfg_load) |=> $stable(table_q));

  // R6: carry-out is quiet outside ripple mode
  assert_co_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q[5:4] != 2'd1) |-> !co);

  // R5: wide output is quiet outside per-half logic mode
  assert_wide_quiet_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q[5:4] != 2'd0) |-> !f_wide);

  // R8: a single-port write is visible at the same address one edge later
  assert_sp_write_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q[5:4] == 2'd2 && c0 && !cfg_load) |=> (!$stable(a) || f == $past(wd)));

  // R10: RAM modes with c0 low keep the table
  assert_c0_low_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q[5:4] >= 2'd2 && !c0 && !cfg_load) |=> $stable(table_q));
endmodule

bind mlut_cell mlut_cell_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
  .a(a), .c0(c0), .wd(wd), .f(f), .f_wide(f_wide), .co(co),
  .mode_q(mode_q), .table_q(table_q)
);

// File: tb/tb_mlut_cell.sv
`timescale 1ns/1ps
module tb_mlut_cell;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [5:0]  cfg_mode;
  logic [63:0] cfg_table;
  logic [4:0]  a, b;
  logic        c0;
  logic [3:0]  wd;
  logic [3:0]  f;
  logic        f_wide, co;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [63:0] T1 = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [63:0] ADD_T = {4{16'hE896}};
  localparam logic [63:0] SUB_T = {4{16'hD469}};

  always #10 clk = ~clk;  // 50 MHz

  mlut_cell dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_table(cfg_table), .a(a), .b(b), .c0(c0), .wd(wd),
    .f(f), .f_wide(f_wide), .co(co)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drv(logic [4:0] av, logic [4:0] bv, logic cv, logic [3:0] wv);
    @(negedge clk);
    a = av; b = bv; c0 = cv; wd = wv;
    #5;
  endtask

  task automatic load(logic [5:0] m, logic [63:0] t);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = m; cfg_table = t; c0 = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_load = 1'b0; cfg_mode = '0; cfg_table = '0;
    a = 5'd7; b = 5'd19; c0 = 1'b1; wd = 4'hF;
    #25;
    chk("R1 reset outputs", {2'b0, co, f_wide, f}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    c0 = 1'b0;
    #5;
    chk("R1 after release", {2'b0, co, f_wide, f}, 8'h00);
  endtask

  task automatic t_split();
    load(6'b00_00_00, T1);
    for (int k = 0; k < 6; k++) begin
      logic [4:0] av, bv;
      logic [3:0] e;
      av = 5'((k*7 + 3) & 31);
      bv = 5'((k*13 + 5) & 31);
      drv(av, bv, 1'b0, 4'h0);
      e[0] = T1[bv[3:0]];
      e[1] = T1[16 + {bv[4], bv[2:0]}];
      e[2] = T1[32 + av[3:0]];
      e[3] = T1[48 + {av[4], av[2:0]}];
      chk("R3 split", {4'b0, f}, {4'b0, e});
      chk("R5 wide c0=0", {7'b0, f_wide}, {7'b0, T1[bv]});
      drv(av, bv, 1'b1, 4'h0);
      chk("R5 wide c0=1", {7'b0, f_wide}, {7'b0, T1[32 + av]});
    end
  endtask

  task automatic t_func5();
    load(6'b00_01_01, T1);
    for (int k = 0; k < 5; k++) begin
      logic [4:0] av, bv;
      av = 5'((k*11 + 1) & 31);
      bv = 5'((k*5 + 17) & 31);
      drv(av, bv, 1'b0, 4'h0);
      chk("R4 five-input", {4'b0, f},
          {4'b0, T1[32+av], T1[32+av], T1[bv], T1[bv]});
    end
  endtask

  task automatic t_ripple();
    load(6'b01_00_00, ADD_T);
    for (int k = 0; k < 8; k++) begin
      logic [3:0] av, bv;
      logic       cin;
      logic [4:0] s;
      av = 4'((k*5 + 9) & 15);
      bv = 4'((k*3 + 14) & 15);
      cin = k[0];
      s = av + bv + 5'(cin);
      drv({1'b0, av}, {cin, bv}, 1'b1, 4'(k));
      chk("R6 ripple add", {3'b0, co, f}, {3'b0, s});
      chk("R5 wide quiet in ripple", {7'b0, f_wide}, 8'h00);
    end
    load(6'b01_00_00, SUB_T);
    for (int k = 0; k < 4; k++) begin
      logic [3:0] av, bv;
      av = 4'((k*6 + 2) & 15);
      bv = 4'((k*4 + 5) & 15);
      drv({1'b0, av}, {1'b1, bv}, 1'b0, 4'h0);
      chk("R6 ripple sub", {3'b0, co, f}, {3'b0, (av >= bv), 4'(av - bv)});
    end
  endtask

  task automatic t_aram();
    load(6'b00_10_10, 64'h0);
    drv(5'd3, 5'd9, 1'b1, 4'b1101);
    chk("R7 clock-low bypass", {4'b0, f}, 8'h0D);
    drv(5'd3, 5'd9, 1'b0, 4'b0000);
    chk("R7 stored", {4'b0, f}, 8'h0D);
    drv(5'd4, 5'd9, 1'b0, 4'b0000);
    chk("R7 other address", {4'b0, f}, 8'h01);
    drv(5'd3, 5'd9, 1'b0, 4'b0010);
    drv(5'd3, 5'd9, 1'b0, 4'b0000);
    chk("R10 c0 low no write", {4'b0, f}, 8'h0D);
  endtask

  task automatic t_spram();
    load(6'b10_00_00, T1);
    drv(5'd7, 5'd0, 1'b1, 4'b1010);
    chk("R8 read before edge", {4'b0, f}, {4'b0, T1[55], T1[39], T1[23], T1[7]});
    chk("R5 wide quiet in RAM", {7'b0, f_wide}, 8'h00);
    drv(5'd7, 5'd0, 1'b0, 4'b0000);
    chk("R8 written", {4'b0, f}, 8'h0A);
    drv(5'd8, 5'd0, 1'b0, 4'b0000);
    chk("R8 neighbour kept", {4'b0, f}, {4'b0, T1[56], T1[40], T1[24], T1[8]});
    // load and write at the same edge: load wins
    @(negedge clk);
    a = 5'd7; c0 = 1'b1; wd = 4'b0101;
    cfg_load = 1'b1; cfg_mode = 6'b10_00_00; cfg_table = 64'h0;
    @(negedge clk);
    cfg_load = 1'b0; c0 = 1'b0;
    #5;
    chk("R2 load beats write", {4'b0, f}, 8'h00);
  endtask

  task automatic t_dpram();
    load(6'b11_00_00, 64'h0);
    drv(5'd5, 5'd5, 1'b1, 4'b0011);
    chk("R9 same-address read old", {4'b0, f}, 8'h00);
    drv(5'd5, 5'd5, 1'b0, 4'b0000);
    chk("R9 written copies", {4'b0, f}, 8'h0F);
    drv(5'd6, 5'd5, 1'b0, 4'b0000);
    chk("R9 separate read port", {4'b0, f}, 8'h0C);
    drv(5'd5, 5'd5, 1'b0, 4'b1100);
    drv(5'd5, 5'd5, 1'b0, 4'b0000);
    chk("R10 dual-port c0 low", {4'b0, f}, 8'h0F);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_split();
    t_func5();
    t_ripple();
    t_aram();
    t_spram();
    t_dpram();
    done = 1'b1;
    finish_run();
  end
endmodule